// File: doc/BRIEF.md
# Pipelined Saturating Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a fixed-point signal-processing core. Each cycle in which `inValid` is high it takes two 16-bit operands, widens each to 17 bits with sign or zero extension under its own control bit, and multiplies them in two's complement. The product can be doubled in fractional mode. It is then added to, subtracted from, or loaded into one of two 40-bit accumulators, either as it is or negated.

The work is split across two pipeline stages. The product is registered in the first stage, and the second stage updates the chosen accumulator through a 40-bit adder. A new product can therefore be formed in the same cycle that the previous one is accumulated. When saturation is enabled, any result outside the signed 32-bit range is replaced by the nearest extreme. Each accumulator can be read as separate guard, high and low fields. Each one also has a sticky overflow flag.

Top module: `mac_unit`

## Requirements
- R1: The operands are widened to 17 bits, by sign extension when `aSigned`/`bSigned` is 1 and by zero extension when it is 0. The 17 x 17 product is exact in two's complement.
- R2: `opSel` encodes the update: 00 gives acc + product, 01 gives acc - product, 10 gives product, and 11 gives -product. `dstSel` = 0 writes accumulator A and 1 writes B. The other accumulator is left unchanged.
- R3: Each accumulator is presented as guard (bits 39..32), high (31..16) and low (15..0) output fields.
- R4: When `fracMode` is 1 at issue, the product is shifted left by one bit before it is accumulated.
- R5: When `satMode` is 1 at issue and the 40-bit result lies outside -2^31..2^31-1, the destination is loaded with 0x007FFFFFFF if the result is positive and 0xFF80000000 if it is negative.
- R6: When `satMode` is 0, the result is kept wrapped modulo 2^40.
- R7: An overflow (a result outside the signed 32-bit range, in either mode) sets the destination's flag. The flag stays set until `clrOvf` is sampled high; if an overflow happens at the same edge as the clear, the flag is set.
- R8: An operation accepted at clock edge k updates its accumulator at edge k+1, and `outValid` is high in the cycle after edge k+1. N back-to-back operations finish in N+1 cycles.
- R9: After reset, both accumulators are zero, both flags are clear and `outValid` is low.
- R10: Cycles with `inValid` low change no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| aSigned | input | 1 | 1 sign-extends opA, 0 zero-extends |
| bSigned | input | 1 | 1 sign-extends opB, 0 zero-extends |
| fracMode | input | 1 | Double the product |
| satMode | input | 1 | Saturate to the 32-bit signed range on overflow |
| dstSel | input | 1 | 0 selects accumulator A, 1 selects B |
| opSel | input | 2 | Update kind: add, subtract, load, load negated |
| clrOvf | input | 1 | Clear both overflow flags |
| outValid | output | 1 | An accumulator update completed at the last edge |
| accAGuard | output | 8 | Accumulator A bits 39..32 |
| accAHigh | output | 16 | Accumulator A bits 31..16 |
| accALow | output | 16 | Accumulator A bits 15..0 |
| accBGuard | output | 8 | Accumulator B bits 39..32 |
| accBHigh | output | 16 | Accumulator B bits 31..16 |
| accBLow | output | 16 | Accumulator B bits 15..0 |
| ovfA | output | 1 | Sticky overflow flag of A |
| ovfB | output | 1 | Sticky overflow flag of B |

## Verification
The hardest condition to reach is a carry out of the 40-bit accumulator itself with saturation off. Even one full-scale product is far from 2^40. The stimulus gets there with a long back-to-back run of doubled unsigned full-scale products, which climbs past 2^39 and wraps. A flag clear that coincides with a fresh overflow is set up by issuing the overflowing load one cycle before raising the clear. A reference model written with integers follows every cycle, including the one-cycle overlap between the two pipeline stages.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_LOAD    = 2'b10,
    OP_LOADNEG = 2'b11
  } macOp_e;

  // strobes from control to datapath for the accumulate stage
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic useAcc;
    logic negate;
    logic saturate;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       dstSel,
  input  logic       satMode,
  input  logic [1:0] opSel,
  output macStrobe_t strobe,
  output logic       outValid
);
  logic   vld1, dst1, sat1;
  macOp_e op1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld1     <= 1'b0;
      dst1     <= 1'b0;
      sat1     <= 1'b0;
      op1      <= OP_ADD;
      outValid <= 1'b0;
    end else begin
      vld1     <= inValid;
      outValid <= vld1;
      if (inValid) begin
        dst1 <= dstSel;
        sat1 <= satMode;
        op1  <= macOp_e'(opSel);
      end
    end
  end

  always_comb begin
    strobe.wrA      = vld1 & ~dst1;
    strobe.wrB      = vld1 & dst1;
    strobe.useAcc   = (op1 == OP_ADD) || (op1 == OP_SUB);
    strobe.negate   = (op1 == OP_SUB) || (op1 == OP_LOADNEG);
    strobe.saturate = sat1;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             aSigned,
  input  logic             bSigned,
  input  logic             fracMode,
  input  logic             clrOvf,
  input  macStrobe_t       strobe,
  output logic [ACC_W-1:0] accA,
  output logic [ACC_W-1:0] accB,
  output logic             ovfA,
  output logic             ovfB
);
  localparam int MW = OP_W + 1;
  localparam int PW = 2 * MW;
  localparam int FW = PW + 1;
  localparam int HB = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{HB{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  // stage 1: widen and multiply
  logic signed [MW-1:0] xA, xB;
  logic signed [PW-1:0] rawProd;
  logic signed [FW-1:0] prodQ;

  assign xA      = {aSigned & opA[OP_W-1], opA};
  assign xB      = {bSigned & opB[OP_W-1], opB};
  assign rawProd = xA * xB;

  always_ff @(posedge clk) begin
    if (!rstN)        prodQ <= '0;
    else if (inValid) prodQ <= fracMode ? {rawProd, 1'b0} : {rawProd[PW-1], rawProd};
  end

  // stage 2: add, saturate, write back
  logic [ACC_W-1:0] prodExt, srcAcc, base, sum, result;
  logic [HB-1:0]    hiBits;
  logic             ovfNow;
  logic [1:0]       wrEn;
  logic [ACC_W-1:0] accReg [2];
  logic [1:0]       flagReg;

  assign prodExt = {{(ACC_W-FW){prodQ[FW-1]}}, prodQ};
  assign srcAcc  = strobe.wrB ? accReg[1] : accReg[0];
  assign base    = strobe.useAcc ? srcAcc : '0;
  assign sum     = strobe.negate ? base - prodExt : base + prodExt;
  assign hiBits  = sum[ACC_W-1:SAT_W-1];
  assign ovfNow  = !((&hiBits) || !(|hiBits));
  assign result  = (strobe.saturate && ovfNow) ? (sum[ACC_W-1] ? NEG_LIM : POS_LIM) : sum;
  assign wrEn    = {strobe.wrB, strobe.wrA};

  for (genvar g = 0; g < 2; g++) begin : gAcc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accReg[g]  <= '0;
        flagReg[g] <= 1'b0;
      end else begin
        if (wrEn[g]) accReg[g] <= result;
        if (wrEn[g] && ovfNow) flagReg[g] <= 1'b1;
        else if (clrOvf)       flagReg[g] <= 1'b0;
      end
    end
  end

  assign accA = accReg[0];
  assign accB = accReg[1];
  assign ovfA = flagReg[0];
  assign ovfB = flagReg[1];
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [OP_W-1:0]       opA,
  input  logic [OP_W-1:0]       opB,
  input  logic                  aSigned,
  input  logic                  bSigned,
  input  logic                  fracMode,
  input  logic                  satMode,
  input  logic                  dstSel,
  input  logic [1:0]            opSel,
  input  logic                  clrOvf,
  output logic                  outValid,
  output logic [ACC_W-SAT_W-1:0] accAGuard,
  output logic [SAT_W-OP_W-1:0] accAHigh,
  output logic [OP_W-1:0]       accALow,
  output logic [ACC_W-SAT_W-1:0] accBGuard,
  output logic [SAT_W-OP_W-1:0] accBHigh,
  output logic [OP_W-1:0]       accBLow,
  output logic                  ovfA,
  output logic                  ovfB
);
  macStrobe_t       strobe;
  logic [ACC_W-1:0] accA, accB;

  mac_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dstSel(dstSel),
    .satMode(satMode), .opSel(opSel), .strobe(strobe), .outValid(outValid)
  );

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .fracMode(fracMode), .clrOvf(clrOvf),
    .strobe(strobe), .accA(accA), .accB(accB), .ovfA(ovfA), .ovfB(ovfB)
  );

  assign {accAGuard, accAHigh, accALow} = accA;
  assign {accBGuard, accBHigh, accBLow} = accB;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   satMode,
  input logic                   dstSel,
  input logic                   clrOvf,
  input logic                   outValid,
  input logic [ACC_W-SAT_W-1:0] accAGuard,
  input logic [SAT_W-OP_W-1:0]  accAHigh,
  input logic [OP_W-1:0]        accALow,
  input logic [ACC_W-SAT_W-1:0] accBGuard,
  input logic [SAT_W-OP_W-1:0]  accBHigh,
  input logic [OP_W-1:0]        accBLow,
  input logic                   ovfA,
  input logic                   ovfB
);
  localparam int GW = ACC_W - SAT_W;
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd2) |-> (outValid == $past(inValid, 2))); // R8

  AST_SAT_RANGE_A: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd2 && outValid && $past(satMode, 2) && !$past(dstSel, 2))
      |-> (accAGuard == {GW{accAHigh[SAT_W-OP_W-1]}})); // R5

  AST_SAT_RANGE_B: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd2 && outValid && $past(satMode, 2) && $past(dstSel, 2))
      |-> (accBGuard == {GW{accBHigh[SAT_W-OP_W-1]}})); // R5

  AST_OTHER_ACC_HELD_B: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd2 && outValid && !$past(dstSel, 2))
      |-> ($stable(accBGuard) && $stable(accBHigh) && $stable(accBLow))); // R2

  AST_OTHER_ACC_HELD_A: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd2 && outValid && $past(dstSel, 2))
      |-> ($stable(accAGuard) && $stable(accAHigh) && $stable(accALow))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd1 && !outValid)
      |-> ($stable(accAGuard) && $stable(accAHigh) && $stable(accALow) &&
           $stable(accBGuard) && $stable(accBHigh) && $stable(accBLow))); // R10

  AST_FLAG_STICKY_A: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd1 && $past(ovfA) && !$past(clrOvf)) |-> ovfA); // R7

  AST_FLAG_STICKY_B: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= 2'd1 && $past(ovfB) && !$past(clrOvf)) |-> ovfB); // R7
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .satMode(satMode), .dstSel(dstSel),
  .clrOvf(clrOvf), .outValid(outValid),
  .accAGuard(accAGuard), .accAHigh(accAHigh), .accALow(accALow),
  .accBGuard(accBGuard), .accBHigh(accBHigh), .accBLow(accBLow),
  .ovfA(ovfA), .ovfB(ovfB)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, aSigned = 0, bSigned = 0, fracMode = 0, satMode = 0, dstSel = 0, clrOvf = 0;
  logic [15:0] opA = 0, opB = 0;
  logic [1:0]  opSel = 0;
  logic        outValid, ovfA, ovfB;
  logic [7:0]  accAGuard, accBGuard;
  logic [15:0] accAHigh, accALow, accBHigh, accBLow;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_unit uut (.*);

  // reference model state
  longint mA = 0, mB = 0;
  bit fA = 0, fB = 0, expOut = 0;
  bit pv = 0, pdst = 0, psat = 0;
  logic [1:0] pop = 0;
  longint pprod = 0;
  localparam longint POS = 64'sd2147483647;
  localparam longint NEG = -64'sd2147483648;

  function automatic longint w40(longint x);
    logic [39:0] t = x[39:0];
    return longint'(signed'(t));
  endfunction

  function automatic longint ext16(logic [15:0] v, bit s);
    return s ? longint'(signed'(v)) : longint'(v);
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    longint s, base;
    bit ov;
    if (pv) begin
      base = (pop[1] == 1'b0) ? (pdst ? mB : mA) : 0;
      s  = w40(pop[0] ? base - pprod : base + pprod);
      ov = (s > POS) || (s < NEG);
      if (psat && ov) s = (s < 0) ? NEG : POS;
      if (pdst) begin
        mB = s; fB = ov ? 1'b1 : (clrOvf ? 1'b0 : fB); if (clrOvf) fA = 0;
      end else begin
        mA = s; fA = ov ? 1'b1 : (clrOvf ? 1'b0 : fA); if (clrOvf) fB = 0;
      end
    end else if (clrOvf) begin
      fA = 0; fB = 0;
    end
    expOut = pv;
    pv = inValid;
    if (inValid) begin
      pprod = ext16(opA, aSigned) * ext16(opB, bSigned);
      if (fracMode) pprod = pprod * 2;
      pdst = dstSel; psat = satMode; pop = opSel;
    end
  endtask

  task automatic compare(string tag);
    logic [39:0] aAct, bAct;
    aAct = {accAGuard, accAHigh, accALow};
    bAct = {bAct[39:0]};
    bAct = {accBGuard, accBHigh, accBLow};
    check(aAct == mA[39:0] && bAct == mB[39:0] && ovfA == fA && ovfB == fB && outValid == expOut,
          tag,
          $sformatf("A=%h B=%h fA=%0b fB=%0b v=%0b", aAct, bAct, ovfA, ovfB, outValid),
          $sformatf("A=%h B=%h fA=%0b fB=%0b v=%0b", mA[39:0], mB[39:0], fA, fB, expOut));
  endtask

  task automatic step(bit v, logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr,
                      bit sat, bit dst, logic [1:0] op, bit clr, string tag);
    @(negedge clk);
    inValid = v; opA = a; opB = b; aSigned = as; bSigned = bs; fracMode = fr;
    satMode = sat; dstSel = dst; opSel = op; clrOvf = clr;
    @(posedge clk);
    modelEdge();
    #1 compare(tag);
  endtask

  task automatic idle(string tag);
    step(0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 2'b00, 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [39:0] sumAct;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0.1;
    // R9 reset state
    check({accAGuard, accAHigh, accALow, accBGuard, accBHigh, accBLow} == 80'h0 &&
          !ovfA && !ovfB && !outValid, "R9 reset",
          $sformatf("A=%h B=%h v=%0b", {accAGuard, accAHigh, accALow},
                    {accBGuard, accBHigh, accBLow}, outValid), "all zero");

    // R1 signed x signed, R2 add into A, R3 fields
    step(1, 16'hFFFD, 16'h0007, 1, 1, 0, 0, 0, 2'b10, 0, "R1 signed load");
    step(1, 16'hFFFD, 16'h0007, 0, 1, 0, 0, 0, 2'b00, 0, "R1 mixed add");
    step(1, 16'h8000, 16'h8000, 0, 0, 0, 0, 0, 2'b00, 0, "R1 unsigned add");
    step(1, 16'h8000, 16'h8000, 1, 1, 0, 0, 1, 2'b10, 0, "R2 load B");
    step(1, 16'h1234, 16'h0100, 1, 1, 0, 0, 1, 2'b01, 0, "R2 subtract B");
    step(1, 16'h0005, 16'h0003, 1, 1, 0, 0, 1, 2'b11, 0, "R2 load negated B");
    idle("R10 idle");
    idle("R10 idle");
    step(0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, 0, 2'b10, 0, "R10 invalid ignored");
    idle("R10 invalid ignored");
    idle("R3 fields");
    // R3 explicit field placement: A = 0xFFFFFFFFFD*? check guard/high/low split of model
    check(accAHigh == mA[31:16] && accAGuard == mA[39:32] && accALow == mA[15:0], "R3 split",
          $sformatf("%h %h %h", accAGuard, accAHigh, accALow),
          $sformatf("%h %h %h", mA[39:32], mA[31:16], mA[15:0]));

    // R4 fractional doubling
    step(1, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, 2'b10, 0, "R4 frac load");
    step(1, 16'hC000, 16'h4000, 1, 1, 1, 0, 0, 2'b00, 0, "R4 frac add");
    idle("R4 frac");
    idle("R4 frac");
    check({accAGuard, accAHigh, accALow} == 40'h0, "R4 frac cancel",
          $sformatf("%h", {accAGuard, accAHigh, accALow}), "0000000000");

    // R5 saturation positive and negative, R7 flags
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 0, 2'b10, 0, "R5 sat pos");
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 1, 2'b11, 0, "R5 sat neg");
    idle("R5 sat");
    idle("R5 sat");
    check({accAGuard, accAHigh, accALow} == 40'h007FFFFFFF &&
          {accBGuard, accBHigh, accBLow} == 40'hFF80000000 && ovfA && ovfB, "R5 limits",
          $sformatf("A=%h B=%h", {accAGuard, accAHigh, accALow}, {accBGuard, accBHigh, accBLow}),
          "A=007fffffff B=ff80000000 flags set");
    idle("R7 sticky");
    step(0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 2'b00, 1, "R7 clear");
    check(!ovfA && !ovfB, "R7 cleared", $sformatf("%0b%0b", ovfA, ovfB), "00");
    // R7 set wins over clear at same edge
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 2'b10, 0, "R7 issue");
    step(0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 2'b00, 1, "R7 set beats clear");
    check(ovfA && !ovfB, "R7 set beats clear", $sformatf("%0b%0b", ovfA, ovfB), "10");
    step(0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 2'b00, 1, "R7 clear again");

    // R6 wrap at 40 bits without saturation
    step(1, 16'h0, 16'h0, 0, 0, 0, 0, 1, 2'b10, 0, "R6 zero B");
    for (int i = 0; i < 130; i++)
      step(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 1, 2'b00, 0, "R6 wrap run");
    idle("R6 wrap");
    idle("R6 wrap");
    check({accBGuard, accBHigh, accBLow} == 40'(130 * 64'd8589672450), "R6 wrapped sum",
          $sformatf("%h", {accBGuard, accBHigh, accBLow}), $sformatf("%h", 40'(130 * 64'd8589672450)));

    // R8 burst of 4 finishes after 5 edges
    step(1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 2'b10, 0, "R8 burst");
    step(1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 2'b00, 0, "R8 burst");
    step(1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 2'b00, 0, "R8 burst");
    step(1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 2'b00, 0, "R8 burst");
    step(0, 16'd0, 16'd0, 0, 0, 0, 0, 0, 2'b00, 0, "R8 burst tail");
    sumAct = {accAGuard, accAHigh, accALow};
    check(outValid && sumAct == 40'd60, "R8 N+1 cycles",
          $sformatf("v=%0b A=%0d", outValid, sumAct), "v=1 A=60");
    idle("R8 drain");
    check(!outValid, "R8 valid drops", $sformatf("%0b", outValid), "0");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule